// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12) for Reed-Solomon syndrome and encoder datapaths. The field is a quadratic extension of GF(2^6). Each operand is split into a high 6-bit half and a low 6-bit half. Three GF(64) products are formed in parallel and recombined into the 12-bit result. One further constant GF(64) multiply supplies the extension term.

Operands enter on a valid/ready handshake. The product is held in a single output register, so the result appears one cycle after acceptance. The register can take a new operand in the same cycle that its held result drains. A step-mode input turns the block into the decoder's generator-step function. In that mode operand B is replaced by the constant 0xE01, and an A of zero yields 1.

Top module: `gf4096_mul`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o is 0 until the first operand is accepted.
- R2: With step_mode_i=0, the result is {hi, lo} with hi at bits 11:6 and lo at bits 5:0. The operand halves are ah/al (bits 11:6 / 5:0 of a_i) and bh/bl (of b_i). hi = (ah^al)*(bh^bl) ^ al*bl and lo = (ah*bh)*0x21 ^ al*bl. Each product is in GF(64) with reduction polynomial x^6+x+1 (0x43).
- R3: With step_mode_i=0, a zero in either operand gives a result of 0.
- R4: With step_mode_i=0, an operand equal to 1 gives the other operand as the result.
- R5: With step_mode_i=0, swapping a_i and b_i leaves the result unchanged.
- R6: With step_mode_i=1 and a_i nonzero, the result is a_i multiplied by 0xE01 under the R2 rule. In this mode b_i has no effect.
- R7: With step_mode_i=1 and a_i equal to 0, the result is 1.
- R8: An operand accepted on a clock edge (in_valid_i and in_ready_o both high) gives out_valid_o=1 and its result on prod_o after that same edge.
- R9: While out_valid_o=1 and out_ready_i=0, in_ready_o is 0, and out_valid_o and prod_o hold their values.
- R10: in_ready_o is 1 whenever out_ready_i is 1 or the output register is empty. This allows a new acceptance in the same cycle that a result drains.
- R11: When a result drains (out_valid_o and out_ready_i both high) and no new operand is accepted, out_valid_o falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid |
| in_ready_o | output | 1 | Block can accept operands |
| a_i | input | 12 | Operand A |
| b_i | input | 12 | Operand B (ignored in step mode) |
| step_mode_i | input | 1 | 1: generator-step function of a_i |
| out_valid_o | output | 1 | Result register holds a result |
| out_ready_i | input | 1 | Consumer takes the result |
| prod_o | output | 12 | Result |

## Verification
Two events can fall in the same cycle: the downstream side draining the held result, and the upstream side loading a new product into the same register. The bench presents operands back to back while out_ready_i is toggled at random. This places drain-and-load cycles next to stall cycles and idle drains. A behavioural model of the register tracks the expected state. On every clock the bench checks in_ready_o, out_valid_o and prod_o against that model, so a lost or duplicated result, or a value that changes during a stall, shows as a mismatch.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int unsigned FIELD_W   = 12;
  localparam logic [6:0]  BASE_POLY = 7'h43;  // x^6+x+1
  localparam logic [5:0]  EXT_CONST = 6'h21;  // inverse of GF(64) generator
  localparam logic [11:0] GEN_CONST = 12'hE01;
endpackage

// File: rtl/gf64_mul.sv
// Combinational shift-and-add multiplier over GF(2^W).
module gf64_mul #(
  parameter int unsigned W    = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] z_o
);
  logic [W:0][W-1:0] sh;
  logic [W:0][W-1:0] acc;

  assign sh[0]  = y_i;
  assign acc[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_step
    logic [W:0] wide;
    assign wide       = {sh[i], 1'b0};
    assign sh[i+1]    = wide[W] ? (wide[W-1:0] ^ POLY[W-1:0]) : wide[W-1:0];
    assign acc[i+1]   = x_i[i] ? (acc[i] ^ sh[i]) : acc[i];
  end

  assign z_o = acc[W];
endmodule

// File: rtl/gf_tower_core.sv
// Composite-field product: GF(2^(2H)) as quadratic extension of GF(2^H).
module gf_tower_core #(
  parameter int unsigned FIELD_W   = 12,
  parameter logic [6:0]  BASE_POLY = 7'h43,
  parameter logic [5:0]  EXT_CONST = 6'h21,
  localparam int unsigned HALF_W   = FIELD_W / 2
) (
  input  logic [FIELD_W-1:0] a_i,
  input  logic [FIELD_W-1:0] b_i,
  output logic [FIELD_W-1:0] p_o
);
  logic [HALF_W-1:0] ah, al, bh, bl;
  logic [HALF_W-1:0] p_cross, p_low, p_high, p_ext;

  assign {ah, al} = a_i;
  assign {bh, bl} = b_i;

  gf64_mul #(.W(HALF_W), .POLY(BASE_POLY[HALF_W:0])) u_cross (
    .x_i(ah ^ al), .y_i(bh ^ bl), .z_o(p_cross));
  gf64_mul #(.W(HALF_W), .POLY(BASE_POLY[HALF_W:0])) u_low (
    .x_i(al), .y_i(bl), .z_o(p_low));
  gf64_mul #(.W(HALF_W), .POLY(BASE_POLY[HALF_W:0])) u_high (
    .x_i(ah), .y_i(bh), .z_o(p_high));
  gf64_mul #(.W(HALF_W), .POLY(BASE_POLY[HALF_W:0])) u_ext (
    .x_i(p_high), .y_i(EXT_CONST[HALF_W-1:0]), .z_o(p_ext));

  assign p_o = {p_cross ^ p_low, p_ext ^ p_low};
endmodule

// File: rtl/gf_out_stage.sv
// Single result register with valid/ready; loads while draining.
module gf_out_stage #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready_o  = !full_q || out_ready_i;
  assign out_valid_o = full_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (out_ready_i) begin
      full_q <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(data_o));
  // R8
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);
  // R11
  drain_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o);
endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul #(
  parameter int unsigned FIELD_W   = gf_pkg::FIELD_W,
  parameter logic [6:0]  BASE_POLY = gf_pkg::BASE_POLY,
  parameter logic [5:0]  EXT_CONST = gf_pkg::EXT_CONST,
  parameter logic [11:0] GEN_CONST = gf_pkg::GEN_CONST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [FIELD_W-1:0] a_i,
  input  logic [FIELD_W-1:0] b_i,
  input  logic               step_mode_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [FIELD_W-1:0] prod_o
);
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  logic [FIELD_W-1:0] op_b, core_p, result;

  assign op_b = step_mode_i ? GEN_CONST[FIELD_W-1:0] : b_i;

  gf_tower_core #(
    .FIELD_W(FIELD_W), .BASE_POLY(BASE_POLY), .EXT_CONST(EXT_CONST)
  ) u_core (
    .a_i(a_i), .b_i(op_b), .p_o(core_p)
  );

  // generator step maps 0 to 1
  assign result = (step_mode_i && a_i == '0) ? ONE : core_p;

  gf_out_stage #(.W(FIELD_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .data_i(result),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .data_o(prod_o)
  );

  // R3
  zero_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !step_mode_i && (a_i == '0 || b_i == '0)
    |=> prod_o == '0);
  // R7
  step_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && step_mode_i && a_i == '0 |=> prod_o == ONE);
  // R4
  ident_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !step_mode_i && a_i == ONE |=> prod_o == $past(b_i));
endmodule

// File: tb/gf4096_mul_tb.sv
module gf4096_mul_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, step = 1'b0, out_ready = 1'b1;
  logic [11:0] a = '0, b = '0;
  logic in_ready, out_valid;
  logic [11:0] prod;

  int checks = 0, errs = 0;
  bit stall_mode = 0;
  bit done = 0;

  // model state
  bit mv = 0, acc_f = 0;
  logic [11:0] mp = '0;
  string mtag = "R2", ttag = "R2";
  int ovr = -1;
  logic [11:0] comm_q[$];

  always #2 clk = ~clk;  // 250 MHz

  gf4096_mul u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .step_mode_i(step), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .prod_o(prod));

  function automatic int m64(int x, int y);
    int c = 0;
    for (int i = 0; i < 6; i++) begin
      if ((x >> i) & 1) c ^= y;
      y = y << 1;
      if (y & 64) y ^= 67;
    end
    return c & 63;
  endfunction

  function automatic logic [11:0] mref(int x, int y);
    int xh = x >> 6, xl = x & 63, yh = y >> 6, yl = y & 63;
    int hi = m64(xh ^ xl, yh ^ yl) ^ m64(xl, yl);
    int lo = m64(m64(xh, yh), 33) ^ m64(xl, yl);
    return 12'((hi << 6) | lo);
  endfunction

  function automatic logic [11:0] expect_of(logic [11:0] x, logic [11:0] y, logic s);
    if (s) return (x == 0) ? 12'd1 : mref(x, 12'hE01);
    return mref(x, y);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference register
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mv <= 0; acc_f <= 0;
    end else begin
      automatic bit rdy = !mv || out_ready;
      acc_f <= in_valid && rdy;
      if (in_valid && rdy) begin
        mv   <= 1;
        mp   <= (ovr >= 0) ? 12'(ovr) : expect_of(a, b, step);
        mtag <= ttag;
      end else if (out_ready) mv <= 0;
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(mv ? "R8" : "R11", out_valid, mv);
      chk((mv && !out_ready) ? "R9" : "R10", in_ready, !mv || out_ready);
      if (mv) chk(mtag, prod, mp);
      if (mv && out_ready && mtag == "R5") comm_q.push_back(prod);
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic op(logic [11:0] x, logic [11:0] y, logic s, string tag, int o);
    a = x; b = y; step = s; ttag = tag; ovr = o; in_valid = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (acc_f) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", out_valid, 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", out_valid, 0);

    // R2 random products, free-flowing then stalled
    for (int i = 0; i < 40; i++) op(12'($urandom), 12'($urandom), 0, "R2", -1);
    idle(2);
    stall_mode = 1;
    for (int i = 0; i < 40; i++) op(12'($urandom), 12'($urandom), 0, "R2", -1);
    idle(4);
    stall_mode = 0;
    idle(2);

    // R3 zero operand
    for (int i = 0; i < 6; i++) begin
      op(12'h000, 12'($urandom), 0, "R3", 0);
      op(12'($urandom), 12'h000, 0, "R3", 0);
    end
    op(12'h000, 12'h000, 0, "R3", 0);
    // R4 identity
    for (int i = 0; i < 6; i++) begin
      automatic logic [11:0] v = 12'($urandom);
      op(12'h001, v, 0, "R4", v);
      op(v, 12'h001, 0, "R4", v);
    end
    op(12'hFFF, 12'h001, 0, "R4", 12'hFFF);
    idle(2);

    // R5 swapped operands
    for (int i = 0; i < 8; i++) begin
      automatic logic [11:0] x = 12'($urandom), y = 12'($urandom);
      op(x, y, 0, "R5", -1);
      op(y, x, 0, "R5", -1);
    end
    idle(3);
    chk("R5", comm_q.size(), 16);
    for (int i = 0; i + 1 < comm_q.size(); i += 2) chk("R5", comm_q[i], comm_q[i+1]);

    // R6 step mode, b varied and ignored
    for (int i = 0; i < 10; i++) begin
      automatic logic [11:0] x = 12'($urandom | 1);
      op(x, 12'($urandom), 1, "R6", mref(x, 12'hE01));
      op(x, ~b, 1, "R6", mref(x, 12'hE01));
    end
    // R7 step mode zero input
    op(12'h000, 12'h123, 1, "R7", 1);
    op(12'h000, 12'hFFF, 1, "R7", 1);

    // R10 drain-and-load under stalls, mixed modes
    stall_mode = 1;
    for (int i = 0; i < 30; i++) op(12'($urandom), 12'($urandom), 1'($urandom), "R10", -1);
    stall_mode = 0;
    // R8 single op then R11 idle drain
    op(12'h801, 12'h0C3, 0, "R8", -1);
    idle(3);
    chk("R11", out_valid, 0);
    finish_run();
  end
endmodule